// File: doc/BRIEF.md
# Receive-FIFO Flow-Control Watermark Controller

This block sits beside a UART receive FIFO and decides, from the FIFO's fill count alone, whether the far end may keep sending. It drives an active-low handshake line with two watermarks. The line is pulled low (send permitted) while the FIFO has room. It goes high once the fill count climbs to the upper watermark. It is pulled low again only after the host has read the FIFO back down to the lower watermark. A select bit moves the handshake from the RTS pin to the DTR pin. The pin that is not selected idles high.

A separate trigger level raises a data-ready interrupt toward the host. This trigger is independent of the two watermarks, so bytes keep arriving between the trigger and the upper watermark while the host reacts. When automatic control is off, the selected pin follows a manual request bit. Meanwhile the watermark state keeps tracking the FIFO. The three levels are loaded together through one write strobe. A write whose lower watermark is not below its upper watermark is corrected on the way in.

Top module: `rx_flowctl`

## Requirements
- R1: While `rst` is high, `rts_n` and `dtr_n` are 1 and `rx_rdy_irq` is 0.
- R2: One cycle after `fill_lvl` is greater than or equal to the trigger level, `rx_rdy_irq` is 1. Fill counts above the trigger but below the upper watermark leave the handshake pin low.
- R3: With `auto_en`=1, two cycles after `fill_lvl` is greater than or equal to the upper watermark, the selected handshake pin is 1.
- R4: Once high under automatic control, the selected pin stays 1 while `fill_lvl` is above the lower watermark. It returns to 0 two cycles after `fill_lvl` is less than or equal to the lower watermark.
- R5: One cycle after `fill_lvl` is below the trigger level, `rx_rdy_irq` is 0.
- R6: A write with `cfg_we`=1 stores the levels one cycle later, with two corrections. An upper value of 0 is stored as 1. A lower value that is greater than or equal to the stored upper value is stored as upper minus 1.
- R7: `line_sel`=0 routes the handshake to `rts_n` and holds `dtr_n` at 1. `line_sel`=1 routes it to `dtr_n` and holds `rts_n` at 1.
- R8: With `auto_en`=0, the selected pin equals the inverse of `man_req`, one cycle later. The watermark state keeps tracking `fill_lvl` and takes effect again when `auto_en` returns to 1.
- R9: Under automatic control, starting from the send-permitted state, the selected pin stays 0 for every fill count below the upper watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_lvl | input | CNT_W | Current receive FIFO fill count |
| cfg_we | input | 1 | Load the three level fields |
| cfg_hi | input | CNT_W | Upper watermark to load |
| cfg_lo | input | CNT_W | Lower watermark to load |
| cfg_trig | input | CNT_W | Data-ready trigger level to load |
| auto_en | input | 1 | 1 = pin driven by watermarks, 0 = manual |
| line_sel | input | 1 | 0 = handshake on RTS, 1 = on DTR |
| man_req | input | 1 | Manual request, 1 drives the selected pin low |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| rx_rdy_irq | output | 1 | Data-ready interrupt, level |

## Verification
`rx_rdy_irq` is due one cycle after a change of `fill_lvl`. The handshake pins are due two cycles after it: one register holds the watermark state and one holds the pin. A mode or manual-bit change reaches the pins after one cycle. A level write reaches the pins after three cycles. The driver holds every stimulus for three cycles and queues an expectation stamped two cycles after the drive. The monitor compares on the falling edge of exactly that cycle, so every result has settled. After a level write the driver waits without queuing anything until the new levels are in force.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic {
    LINE_RTS = 1'b0,
    LINE_DTR = 1'b1
  } line_sel_e;

  typedef enum logic {
    ST_FLOW = 1'b0,
    ST_STOP = 1'b1
  } hyst_st_e;

  localparam int NUM_LINES = 2;
endpackage

// File: rtl/rxfc_cfg.sv
module rxfc_cfg #(
  parameter int CNT_W    = 7,
  parameter int DEF_HI   = 48,
  parameter int DEF_LO   = 16,
  parameter int DEF_TRIG = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wr_hi,
  input  logic [CNT_W-1:0] wr_lo,
  input  logic [CNT_W-1:0] wr_trig,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q,
  output logic [CNT_W-1:0] trig_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hi_fix, lo_fix;

  always_comb begin
    hi_fix = (wr_hi == '0) ? ONE : wr_hi;
    lo_fix = (wr_lo >= hi_fix) ? (hi_fix - ONE) : wr_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= CNT_W'(DEF_HI);
      lo_q   <= CNT_W'(DEF_LO);
      trig_q <= CNT_W'(DEF_TRIG);
    end else if (we) begin
      hi_q   <= hi_fix;
      lo_q   <= lo_fix;
      trig_q <= wr_trig;
    end
  end

  // R6: stored watermarks are always strictly ordered
  p_thr_order_r6: assert property (@(posedge clk) disable iff (rst)
    hi_q > lo_q);

  // R6: an ordered write lands unchanged
  p_write_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (we && wr_hi != '0 && wr_lo < wr_hi) |=> (hi_q == $past(wr_hi) && lo_q == $past(wr_lo)));
endmodule

// File: rtl/rxfc_hyst.sv
module rxfc_hyst
  import rxfc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  output logic             stop_q
);
  hyst_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FLOW: if (fill >= hi) st_d = ST_STOP;
      ST_STOP: if (fill <= lo) st_d = ST_FLOW;
      default: st_d = ST_FLOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FLOW;
    else     st_q <= st_d;
  end

  assign stop_q = (st_q == ST_STOP);

  p_stop_at_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (fill >= hi) |=> stop_q);

  p_hold_above_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_q && fill > lo) |=> stop_q);

  p_release_at_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (fill <= lo) |=> !stop_q);

  p_flow_below_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (!stop_q && fill < hi) |=> !stop_q);
endmodule

// File: rtl/rxfc_trig.sv
module rxfc_trig #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] trig,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (fill >= trig);
  end

  p_irq_set_r2: assert property (@(posedge clk) disable iff (rst)
    (fill >= trig) |=> irq_q);

  p_irq_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (fill < trig) |=> !irq_q);
endmodule

// File: rtl/rxfc_route.sv
module rxfc_route
  import rxfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      auto_en,
  input  line_sel_e sel,
  input  logic      man_req,
  input  logic      stop,
  output logic      rts_n,
  output logic      dtr_n
);
  logic                 req;
  logic [NUM_LINES-1:0] pin_d, pin_q;

  assign req = auto_en ? !stop : man_req;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign pin_d[g] = (sel == line_sel_e'(g)) ? !req : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '1;
    else     pin_q <= pin_d;
  end

  assign rts_n = pin_q[LINE_RTS];
  assign dtr_n = pin_q[LINE_DTR];

  p_one_line_r7: assert property (@(posedge clk) disable iff (rst)
    !(rts_n == 1'b0 && dtr_n == 1'b0));

  p_idle_dtr_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == LINE_RTS) |=> dtr_n);

  p_manual_r8: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && sel == LINE_RTS) |=> (rts_n == !$past(man_req)));
endmodule

// File: rtl/rx_flowctl.sv
module rx_flowctl
  import rxfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int DEF_HI     = 48,
  parameter int DEF_LO     = 16,
  parameter int DEF_TRIG   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fill_lvl,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic [CNT_W-1:0] cfg_trig,
  input  logic             auto_en,
  input  logic             line_sel,
  input  logic             man_req,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             rx_rdy_irq
);
  logic [CNT_W-1:0] hi_q, lo_q, trig_q;
  logic             stop;

  rxfc_cfg #(
    .CNT_W(CNT_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO), .DEF_TRIG(DEF_TRIG)
  ) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we),
    .wr_hi(cfg_hi), .wr_lo(cfg_lo), .wr_trig(cfg_trig),
    .hi_q(hi_q), .lo_q(lo_q), .trig_q(trig_q)
  );

  rxfc_hyst #(.CNT_W(CNT_W)) hyst_i (
    .clk(clk), .rst(rst), .fill(fill_lvl),
    .hi(hi_q), .lo(lo_q), .stop_q(stop)
  );

  rxfc_trig #(.CNT_W(CNT_W)) trig_i (
    .clk(clk), .rst(rst), .fill(fill_lvl),
    .trig(trig_q), .irq_q(rx_rdy_irq)
  );

  rxfc_route route_i (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .sel(line_sel_e'(line_sel)), .man_req(man_req), .stop(stop),
    .rts_n(rts_n), .dtr_n(dtr_n)
  );

  // R1: outputs idle right after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rts_n && dtr_n && !rx_rdy_irq));
endmodule

// File: tb/rx_flowctl_tb_top.sv
module rx_flowctl_tb_top;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] fill_lvl = '0;
  logic             cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_hi = '0, cfg_lo = '0, cfg_trig = '0;
  logic             auto_en = 1'b1, line_sel = 1'b0, man_req = 1'b0;
  logic             rts_n, dtr_n, rx_rdy_irq;

  always #2.5 clk = ~clk;

  rx_flowctl dut_i (
    .clk(clk), .rst(rst), .fill_lvl(fill_lvl),
    .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_trig(cfg_trig),
    .auto_en(auto_en), .line_sel(line_sel), .man_req(man_req),
    .rts_n(rts_n), .dtr_n(dtr_n), .rx_rdy_irq(rx_rdy_irq)
  );

  typedef struct {
    int    due;
    logic  rts;
    logic  dtr;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  int   m_hi, m_lo, m_trig;
  bit   m_stop = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(rts_n == e.rts, e.tag, "rts_n", int'(rts_n), int'(e.rts));
      chk(dtr_n == e.dtr, e.tag, "dtr_n", int'(dtr_n), int'(e.dtr));
      chk(rx_rdy_irq == e.irq, e.tag, "rx_rdy_irq", int'(rx_rdy_irq), int'(e.irq));
    end
  end

  task automatic write_cfg(input int hi, input int lo, input int trig);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_hi = CNT_W'(hi); cfg_lo = CNT_W'(lo); cfg_trig = CNT_W'(trig);
    @(negedge clk);
    cfg_we = 1'b0;
    // R6 model: upper 0 -> 1, lower not below upper -> upper-1
    m_hi   = (hi == 0) ? 1 : hi;
    m_lo   = (lo >= m_hi) ? m_hi - 1 : lo;
    m_trig = trig;
    repeat (3) @(negedge clk);
  endtask

  // driver: apply one fill count with the current mode, queue expectation
  task automatic step(input int f, input string tag);
    exp_t e;
    bit   req;
    @(negedge clk);
    fill_lvl = CNT_W'(f);
    if (f >= m_hi)      m_stop = 1;
    else if (f <= m_lo) m_stop = 0;
    req   = auto_en ? !m_stop : man_req;
    e.due = cyc + 2;
    e.rts = (line_sel == 1'b0) ? !req : 1'b1;
    e.dtr = (line_sel == 1'b1) ? !req : 1'b1;
    e.irq = (f >= m_trig);
    e.tag = tag;
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rts_n === 1'b1, "R1", "rts_n in reset", int'(rts_n), 1);
    chk(dtr_n === 1'b1, "R1", "dtr_n in reset", int'(dtr_n), 1);
    chk(rx_rdy_irq === 1'b0, "R1", "irq in reset", int'(rx_rdy_irq), 0);
    rst = 1'b0;
    m_hi = 48; m_lo = 16; m_trig = 32;

    write_cfg(12, 4, 8);
    // R9 / R2 / R3: fill up past the trigger and the upper watermark
    for (int f = 0; f <= 15; f++)
      step(f, (f < 8) ? "R9" : (f < 12) ? "R2" : "R3");
    // R4 / R5: slow drain, pin held high down to the lower watermark
    for (int f = 14; f >= 0; f--)
      step(f, (f < 8 && f > 4) ? "R5" : "R4");

    // R6: lower above upper is corrected to upper-1 (10/9)
    write_cfg(10, 14, 5);
    for (int f = 0; f <= 11; f++) step(f, "R6");
    for (int f = 11; f >= 8; f--) step(f, "R6");

    // R6: upper 0 becomes 1, lower becomes 0
    write_cfg(0, 0, 3);
    step(1, "R6");
    step(0, "R6");

    // R7: handshake on DTR
    write_cfg(6, 2, 4);
    line_sel = 1'b1;
    for (int f = 0; f <= 7; f++) step(f, "R7");
    for (int f = 6; f >= 0; f--) step(f, "R7");
    line_sel = 1'b0;

    // R8: manual mode, state keeps tracking in the background
    auto_en = 1'b0;
    man_req = 1'b1; step(0, "R8");
    man_req = 1'b0; step(3, "R8");
    man_req = 1'b1; step(7, "R8");
    line_sel = 1'b1; man_req = 1'b0; step(5, "R8");
    line_sel = 1'b0; man_req = 1'b1; step(4, "R8");
    auto_en = 1'b1; step(4, "R8");
    step(2, "R8");

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R4", "queue drained", q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule